// File: doc/BRIEF.md
# Configurable Registered ROM Read Path

A byte-wide read-only store whose read path is pipelined through an output register. Each clock edge fetches the byte at the current read address. The outputs then show that registered byte until the next edge. Three configuration bits, held in a byte placed just above the data array, choose how the read path works:

- whether the address is taken live or through a hold register controlled by a latch-enable input;
- which level of that latch-enable input counts as active;
- whether the output-enable flag follows the enable pin at once or only at clock edges.

A byte-write programming port fills both the array and the configuration byte. Setting `ADDR_W` to 15 gives the full 32K-byte array; the default is kept smaller so that elaboration stays light. The output-enable flag stands in for a tri-state driver: when it is low, the consumer treats the data bus as undriven.

Top module: `cfg_reg_rom`

## Requirements
- R1: A byte written through the programming port at an address below 2**ADDR_W is the byte later read from that address.
- R2: The output register loads on the rising clock edge. A change of read address during the low phase of the clock leaves `dout` unchanged until the next rising edge, after which it shows the new byte.
- R3: While reset is asserted, `dout` is 0x00, the configuration is all zero and the registered enable is cleared. Directly after reset the enable therefore works asynchronously.
- R4: A programming write to address 2**ADDR_W sets the configuration from bits 2..0 of the data, and higher data bits are dropped. Bit 0 set selects registered enable, bit 1 set selects latched address, and bit 2 set makes the latch enable active low.
- R5: With configuration bit 1 clear, the read address is `addr` on every edge, whatever the level of `ale`.
- R6: With configuration bit 1 set and the latch enable active, the read address is `addr`. While the latch enable is inactive, the read address is the value `addr` had at the last rising edge where the latch enable was active. That held value is 0 after reset.
- R7: With configuration bit 2 set, `ale` low is the active level of the latch enable. With bit 2 clear, `ale` high is the active level.
- R8: With configuration bit 0 clear, `dout_oe` equals the inverse of `en_n` with no clock involved.
- R9: With configuration bit 0 set, `dout_oe` takes the inverse of `en_n` as sampled at each rising edge, and holds that value between edges.
- R10: Programming writes to addresses above 2**ADDR_W change neither the array nor the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads the output register |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Read address |
| ale | input | 1 | Address latch enable, polarity set by configuration |
| en_n | input | 1 | Active-low output enable |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | High when the data bus is driven |
| pgm_we | input | 1 | Programming write strobe |
| pgm_addr | input | ADDR_W+1 | Programming address; 2**ADDR_W is the configuration byte |
| pgm_data | input | DATA_W | Programming data |

## Verification
If the hold register goes wrong, latched mode returns a byte from the wrong address. This shows on `dout` one edge after the latch enable goes inactive, and it persists until the latch enable becomes active again. A wrong polarity bit inverts which reads are live and which are held, so it is visible on the first read of a latched sequence. A wrong enable mode shows within one clock phase: in asynchronous mode `dout_oe` lags an `en_n` change made during the low phase, and in synchronous mode it follows that change before the edge. A configuration byte stored wrongly after an over-range write changes one of those three behaviours on the next read.

// File: rtl/cfg_reg_rom.sv
module cfg_reg_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ale,
  input  logic              en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              pgm_we,
  input  logic [ADDR_W:0]   pgm_addr,
  input  logic [DATA_W-1:0] pgm_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CFG_W = 3;
  localparam logic [ADDR_W:0] CFG_ADDR = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CFG_W-1:0]  cfg_q;
  logic [ADDR_W-1:0] held_q;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;
  logic [1:0]        seen_q;

  wire sync_oe  = cfg_q[0];
  wire latch_on = cfg_q[1];
  wire ale_low  = cfg_q[2];
  wire ale_act  = ale ^ ale_low;
  wire [ADDR_W-1:0] eff_addr = (latch_on && !ale_act) ? held_q : addr;

  always_ff @(posedge clk) begin
    if (pgm_we && !pgm_addr[ADDR_W])
      mem[pgm_addr[ADDR_W-1:0]] <= pgm_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      held_q <= '0;
      data_q <= '0;
      oe_q   <= 1'b0;
      seen_q <= 2'd0;
    end else begin
      if (pgm_we && pgm_addr == CFG_ADDR)
        cfg_q <= pgm_data[CFG_W-1:0];
      if (ale_act)
        held_q <= addr;
      data_q <= mem[eff_addr];
      oe_q   <= !en_n;
      if (seen_q != 2'd3)
        seen_q <= seen_q + 2'd1;
    end
  end

  assign dout    = data_q;
  assign dout_oe = sync_oe ? oe_q : !en_n;

  // R9
  sync_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd0 && sync_oe) |-> (dout_oe == !$past(en_n)));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd0 && !$past(ale_act)) |-> $stable(held_q));

  // R4
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_we && pgm_addr == CFG_ADDR) |=> (cfg_q == $past(pgm_data[CFG_W-1:0])));

  // R2
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd3 && $past(eff_addr) == $past(eff_addr, 2)
     && !$past(pgm_we) && !$past(pgm_we, 2)) |-> $stable(dout));
endmodule

// File: tb/cfg_reg_rom_test.sv
module cfg_reg_rom_test;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ale, en_n;
  logic [7:0]    dout;
  logic          dout_oe;
  logic          pgm_we;
  logic [AW:0]   pgm_addr;
  logic [7:0]    pgm_data;

  cfg_reg_rom #(.ADDR_W(AW), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ale(ale), .en_n(en_n),
    .dout(dout), .dout_oe(dout_oe), .pgm_we(pgm_we),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data));

  typedef struct {
    logic [7:0] v;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 5));
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    exp_t e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(dout, e.v, e.req);
    end
  end

  task automatic rd(input int a, input logic ale_v, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = AW'(a);
    ale  = ale_v;
    exp_q.push_back('{v: exp, req: req});
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic pw(input int a, input logic [7:0] d);
    @(negedge clk);
    pgm_we = 1'b1;
    pgm_addr = (AW+1)'(a);
    pgm_data = d;
    @(negedge clk);
    pgm_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; ale = 1'b0; en_n = 1'b0;
    pgm_we = 1'b0; pgm_addr = '0; pgm_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dout, 8'h00, "R3 dout");
    chk(dout_oe, 1, "R3 async enable after reset");
    en_n = 1'b1; #1;
    chk(dout_oe, 0, "R8 disable");
    en_n = 1'b0;

    for (int a = 0; a < DEPTH; a++) pw(a, pat(a));

    // R6: held address is zero after reset
    pw(DEPTH, 8'h02);
    rd(5, 1'b0, pat(0), "R6 held reset value");
    drain();

    // R10: over-range write leaves configuration at zero
    pw(DEPTH, 8'h00);
    pw(DEPTH + 1, 8'h07);
    rd(9, 1'b0, pat(9), "R10 still transparent");
    drain();
    en_n = 1'b1; #1;
    chk(dout_oe, 0, "R10 still async");
    en_n = 1'b0; #1;
    chk(dout_oe, 1, "R10 still async");

    for (int c = 0; c < 8; c++) begin
      logic act;
      int a1, a2, a3;
      act = (c & 4) ? 1'b0 : 1'b1;
      a1 = (c * 97 + 3) % DEPTH;
      a2 = DEPTH - 1 - c * 13;
      a3 = (c * 211 + 50) % DEPTH;
      drain();
      pw(DEPTH, 8'hF8 | 8'(c));
      rd(a1, act, pat(a1), "R1 live read");
      if (c & 2) begin
        rd(a2, !act, pat(a1), (c & 4) ? "R7 held" : "R6 held");
        rd(a3, !act, pat(a1), (c & 4) ? "R7 held" : "R6 held");
        rd(a3, act, pat(a3), (c & 4) ? "R7 live" : "R6 live");
      end else begin
        rd(a2, !act, pat(a2), "R5 ale ignored");
        rd(a3, act, pat(a3), "R5 ale ignored");
      end
      drain();
      addr = AW'(a2);
      ale = act;
      #1;
      chk(dout, pat(a3), "R2 no change before edge");
      exp_q.push_back('{v: pat(a2), req: "R2 after edge"});
      drain();
      if (c & 1) begin
        en_n = 1'b1; #1;
        chk(dout_oe, 1, "R9 waits for edge");
        @(posedge clk); #2;
        chk(dout_oe, 0, "R9 disabled at edge");
        @(negedge clk);
        en_n = 1'b0; #1;
        chk(dout_oe, 0, "R9 waits for edge");
        @(posedge clk); #2;
        chk(dout_oe, 1, "R9 enabled at edge");
      end else begin
        en_n = 1'b1; #1;
        chk(dout_oe, 0, "R8 immediate disable");
        en_n = 1'b0; #1;
        chk(dout_oe, 1, "R8 immediate enable");
      end
    end
    drain();
    finish_run();
  end
endmodule